// File: doc/BRIEF.md
# Sticky-Pending Masked Interrupt Controller

This block merges a set of level-sensitive interrupt request lines into a single interrupt output for a processor. Each request line first passes through a multi-flop synchronizer. The synchronized levels form the live line-state vector. Every cycle, that vector is ORed into a sticky pending register, so a request that has already dropped is still remembered. The output is raised while any pending bit is also enabled in the mask register.

Software replaces the mask with a direct write. It acknowledges requests by writing ones to a clear port. Any line that is still high sets its pending bit again at once, so an early clear cannot lose a level request. Read ports return the mask, the pending bits and the live line state. A wide event counter per line counts low-to-high transitions of the synchronized line. Any one counter can be read through an index port with one cycle of latency.

Top module: `lvl_irq_combiner`

## Requirements
- R1: A change on a request line appears on `line_rd` after exactly two rising clock edges (two-flop synchronizer).
- R2: Each cycle the pending register takes (pending with cleared bits removed) OR line state. A pending bit stays 1 after its line returns low.
- R3: `irq_out` is 1 exactly when (pending AND mask) is nonzero. It follows a mask write or a clear in the cycle after the write edge.
- R4: With `pend_clr_we` high, the bits of `pend_clr_data` that are 1 clear their pending bits, and bits that are 0 leave theirs unchanged.
- R5: If a synchronized line is high in the cycle its pending bit is cleared, the set wins and the bit remains 1.
- R6: With `mask_we` high, the mask is replaced entirely by `mask_wdata`. `mask_rd` shows the new value after the edge.
- R7: Reset (`rst_n` low) sets the mask, the pending bits, the line state, every counter and the counter read data to zero.
- R8: A line's counter adds 1 for each low-to-high transition of its synchronized line. A line held high for many cycles adds exactly 1.
- R9: A counter at its all-ones value wraps to zero on its next event, with no flag.
- R10: `cnt_rdata` returns the counter selected by `cnt_idx` (bit index of the line) one clock edge after the index is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_lines | input | NUM_LINES | Asynchronous level request lines |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | NUM_LINES | New mask value |
| pend_clr_we | input | 1 | Pending clear strobe |
| pend_clr_data | input | NUM_LINES | Ones select pending bits to clear |
| cnt_idx | input | clog2(NUM_LINES) | Counter select index |
| mask_rd | output | NUM_LINES | Current mask |
| pend_rd | output | NUM_LINES | Current pending bits |
| line_rd | output | NUM_LINES | Synchronized line state |
| cnt_rdata | output | CNT_W | Selected counter value, registered |
| irq_out | output | 1 | Interrupt toward the processor |

## Verification
The bench builds the block with NUM_LINES = 8 and CNT_W = 4. Eight lines let it sweep every line on its own and all 256 mask values against a fixed pending pattern, and check the output arithmetically each time. A 4-bit counter reaches its wrap point within sixteen events, so the wrap and the held-high single count can be checked on real counters in a few hundred cycles.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int unsigned IRQC_LINES_DFLT = 32;
    localparam int unsigned IRQC_CNT_W_DFLT = 64;
    localparam int unsigned IRQC_SYNC_DFLT  = 2;

    typedef enum logic {
        CNT_HOLD = 1'b0,
        CNT_STEP = 1'b1
    } cnt_op_e;
endpackage

// File: rtl/irqc_line_sync.sv
`timescale 1ns/1ps
module irqc_line_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[g] <= '0;
                else         stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_pend_core.sv
`timescale 1ns/1ps
module irqc_pend_core #(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_LINES-1:0] line_i,
    input  logic                 mask_we_i,
    input  logic [NUM_LINES-1:0] mask_wdata_i,
    input  logic                 clr_we_i,
    input  logic [NUM_LINES-1:0] clr_bits_i,
    output logic [NUM_LINES-1:0] mask_o,
    output logic [NUM_LINES-1:0] pend_o,
    output logic                 irq_o
);
    typedef struct packed {
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] pend;
    } core_t;

    core_t st_d, st_q;
    logic [NUM_LINES-1:0] clr_eff;

    always_comb begin
        st_d    = st_q;
        clr_eff = clr_we_i ? clr_bits_i : '0;
        st_d.pend = (st_q.pend & ~clr_eff) | line_i;
        if (mask_we_i) st_d.mask = mask_wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign pend_o = st_q.pend;
    assign irq_o  = |(st_q.pend & st_q.mask);

    // R2: a pending bit not cleared never drops
    assert_pend_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(st_q.pend) & ~$past(clr_eff) & ~st_q.pend) == '0));

    // R5: a high line always leaves its pending bit set
    assert_line_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(line_i) & ~st_q.pend) == '0));

    // R4: cleared bits with low lines end at zero
    assert_clear_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_we_i |=> ((st_q.pend & $past(clr_bits_i) & ~$past(line_i)) == '0));

    // R6: mask write replaces the whole mask
    assert_mask_replace_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_we_i |=> (st_q.mask == $past(mask_wdata_i)));

    // R6: without a write the mask holds
    assert_mask_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mask_we_i |=> $stable(st_q.mask));
endmodule

// File: rtl/irqc_event_counters.sv
`timescale 1ns/1ps
module irqc_event_counters
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned CNT_W     = 64,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_LINES-1:0] line_i,
    input  logic [IDX_W-1:0]     rd_idx_i,
    output logic [CNT_W-1:0]     rd_data_o
);
    logic [NUM_LINES-1:0] prev_d, prev_q;
    logic [CNT_W-1:0]     cnt_d [NUM_LINES];
    logic [CNT_W-1:0]     cnt_q [NUM_LINES];
    logic [CNT_W-1:0]     rdata_d, rdata_q;
    cnt_op_e              op [NUM_LINES];

    always_comb begin
        prev_d = line_i;
        for (int i = 0; i < NUM_LINES; i++) begin
            op[i]    = (line_i[i] && !prev_q[i]) ? CNT_STEP : CNT_HOLD;
            cnt_d[i] = (op[i] == CNT_STEP) ? cnt_q[i] + CNT_W'(1) : cnt_q[i];
        end
        rdata_d = '0;
        if (int'(rd_idx_i) < NUM_LINES) rdata_d = cnt_q[rd_idx_i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q  <= '0;
            rdata_q <= '0;
        end else begin
            prev_q  <= prev_d;
            rdata_q <= rdata_d;
        end
    end

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_cnt
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) cnt_q[g] <= '0;
                else         cnt_q[g] <= cnt_d[g];
            end

            // R8: one step per rising edge of the synchronized line
            assert_cnt_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (line_i[g] && !prev_q[g]) |=> (cnt_q[g] == $past(cnt_q[g]) + CNT_W'(1)));

            // R8: no step without a rising edge
            assert_cnt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !(line_i[g] && !prev_q[g]) |=> $stable(cnt_q[g]));

            // R9: all-ones wraps to zero
            assert_cnt_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ((op[g] == CNT_STEP) && (cnt_q[g] == {CNT_W{1'b1}})) |=> (cnt_q[g] == '0));
        end
    endgenerate

    assign rd_data_o = rdata_q;
endmodule

// File: rtl/lvl_irq_combiner.sv
`timescale 1ns/1ps
module lvl_irq_combiner
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_LINES   = IRQC_LINES_DFLT,
    parameter int unsigned CNT_W       = IRQC_CNT_W_DFLT,
    parameter int unsigned SYNC_STAGES = IRQC_SYNC_DFLT,
    localparam int unsigned IDX_W      = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 mask_we,
    input  logic [NUM_LINES-1:0] mask_wdata,
    input  logic                 pend_clr_we,
    input  logic [NUM_LINES-1:0] pend_clr_data,
    input  logic [IDX_W-1:0]     cnt_idx,
    output logic [NUM_LINES-1:0] mask_rd,
    output logic [NUM_LINES-1:0] pend_rd,
    output logic [NUM_LINES-1:0] line_rd,
    output logic [CNT_W-1:0]     cnt_rdata,
    output logic                 irq_out
);
    logic [NUM_LINES-1:0] line_state;

    irqc_line_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i(clk), .rst_ni(rst_n), .async_i(irq_lines), .sync_o(line_state)
    );

    irqc_pend_core #(.NUM_LINES(NUM_LINES)) u_core (
        .clk_i(clk), .rst_ni(rst_n), .line_i(line_state),
        .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
        .clr_we_i(pend_clr_we), .clr_bits_i(pend_clr_data),
        .mask_o(mask_rd), .pend_o(pend_rd), .irq_o(irq_out)
    );

    irqc_event_counters #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W)) u_cnt (
        .clk_i(clk), .rst_ni(rst_n), .line_i(line_state),
        .rd_idx_i(cnt_idx), .rd_data_o(cnt_rdata)
    );

    assign line_rd = line_state;

    // R3: an all-zero mask keeps the output low
    assert_quiet_when_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rd == '0) |-> !irq_out);

    // R3: nothing pending keeps the output low
    assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_rd == '0) |-> !irq_out);
endmodule

// File: tb/lvl_irq_combiner_tb.sv
`timescale 1ns/1ps
module lvl_irq_combiner_tb;
    localparam int N  = 8;
    localparam int CW = 4;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_lines = '0;
    logic          mask_we = 1'b0;
    logic [N-1:0]  mask_wdata = '0;
    logic          pend_clr_we = 1'b0;
    logic [N-1:0]  pend_clr_data = '0;
    logic [IW-1:0] cnt_idx = '0;
    logic [N-1:0]  mask_rd, pend_rd, line_rd;
    logic [CW-1:0] cnt_rdata;
    logic          irq_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    int exp_cnt [N];

    always #10 clk = ~clk;

    lvl_irq_combiner #(.NUM_LINES(N), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .pend_clr_we(pend_clr_we), .pend_clr_data(pend_clr_data),
        .cnt_idx(cnt_idx), .mask_rd(mask_rd), .pend_rd(pend_rd),
        .line_rd(line_rd), .cnt_rdata(cnt_rdata), .irq_out(irq_out)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_lines(input logic [N-1:0] v);
        for (int b = 0; b < N; b++) if (v[b] && !irq_lines[b]) exp_cnt[b]++;
        irq_lines = v;
    endtask

    task automatic write_mask(input logic [N-1:0] m);
        mask_we = 1'b1; mask_wdata = m;
        step(1);
        mask_we = 1'b0;
    endtask

    task automatic clear_pend(input logic [N-1:0] c);
        pend_clr_we = 1'b1; pend_clr_data = c;
        step(1);
        pend_clr_we = 1'b0; pend_clr_data = '0;
    endtask

    task automatic read_cnt(input int idx, input string req);
        cnt_idx = IW'(idx);
        step(1);
        check(req, 64'(cnt_rdata), 64'(exp_cnt[idx] % (1 << CW)));
    endtask

    task automatic pulse(input int i);
        set_lines(irq_lines | (N'(1) << i));
        step(2);
        set_lines(irq_lines & ~(N'(1) << i));
        step(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) exp_cnt[i] = 0;
        step(2);
        // R7 reset state
        check("R7 mask", 64'(mask_rd), 0);
        check("R7 pend", 64'(pend_rd), 0);
        check("R7 line", 64'(line_rd), 0);
        check("R7 irq", 64'(irq_out), 0);
        check("R7 rdata", 64'(cnt_rdata), 0);
        rst_n = 1'b1;
        step(1);
        for (int i = 0; i < N; i++) read_cnt(i, "R7 counter");

        // per-line sweep
        for (int i = 0; i < N; i++) begin
            set_lines(N'(1) << i);
            step(1);
            check("R1 not yet", 64'(line_rd), 0);
            step(1);
            check("R1 line", 64'(line_rd), 64'(N'(1) << i));
            step(1);
            check("R2 pend set", 64'(pend_rd), 64'(N'(1) << i));
            check("R3 masked", 64'(irq_out), 0);
            write_mask(N'(1) << i);
            check("R6 mask", 64'(mask_rd), 64'(N'(1) << i));
            check("R3 raised", 64'(irq_out), 1);
            set_lines('0);
            step(3);
            check("R2 sticky", 64'(pend_rd), 64'(N'(1) << i));
            check("R3 still", 64'(irq_out), 1);
            clear_pend(N'(1) << i);
            check("R4 cleared", 64'(pend_rd), 0);
            check("R3 dropped", 64'(irq_out), 0);
            write_mask('0);
            read_cnt(i, "R10 one event");
        end

        // mask sweep against pending 8'hA5
        set_lines(8'hA5);
        step(3);
        set_lines('0);
        step(3);
        check("R2 pattern", 64'(pend_rd), 64'h A5);
        for (int m = 0; m < 256; m++) begin
            write_mask(N'(m));
            check("R6 sweep", 64'(mask_rd), 64'(m));
            check("R3 sweep", 64'(irq_out), 64'(((m & 8'hA5) != 0) ? 1 : 0));
        end
        write_mask('0);

        // R4 write-one-to-clear leaves zero bits
        clear_pend(8'h0F);
        check("R4 partial", 64'(pend_rd), 64'h A0);
        clear_pend(8'h00);
        check("R4 zero write", 64'(pend_rd), 64'h A0);
        clear_pend(8'hFF);
        check("R4 all", 64'(pend_rd), 0);

        // R5 clear while line held high
        set_lines(8'h08);
        step(3);
        clear_pend(8'hFF);
        check("R5 set wins", 64'(pend_rd), 64'h 08);
        write_mask(8'h08);
        check("R5 irq kept", 64'(irq_out), 1);

        // R8 held high for many cycles adds exactly one
        step(12);
        read_cnt(3, "R8 held");
        set_lines('0);
        step(3);
        clear_pend(8'hFF);
        write_mask('0);
        set_lines(8'h20);
        step(20);
        read_cnt(5, "R8 long hold");
        set_lines('0);
        step(3);

        // R9 wrap on line 1
        begin
            int need;
            need = (1 << CW) - (exp_cnt[1] % (1 << CW));
            for (int k = 0; k < need; k++) pulse(1);
            step(1);
            read_cnt(1, "R9 wrapped");
            check("R9 zero", 64'(cnt_rdata), 0);
            pulse(1);
            step(1);
            read_cnt(1, "R9 after wrap");
        end

        // R10 every index
        for (int i = 0; i < N; i++) read_cnt(i, "R10 index");

        // R7 mid-run reset
        set_lines(8'h3C);
        write_mask(8'hFF);
        step(4);
        set_lines('0);
        rst_n = 1'b0;
        for (int i = 0; i < N; i++) exp_cnt[i] = 0;
        step(1);
        check("R7 mid mask", 64'(mask_rd), 0);
        check("R7 mid pend", 64'(pend_rd), 0);
        check("R7 mid line", 64'(line_rd), 0);
        check("R7 mid irq", 64'(irq_out), 0);
        rst_n = 1'b1;
        step(1);
        for (int i = 0; i < N; i++) read_cnt(i, "R7 mid counter");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule